// File: doc/BRIEF.md
# Prediction Restriction Command Trap Router

This block settles what happens when software running in a 32-bit execution state tries to issue the cache-prefetch prediction restriction command through the coprocessor instruction space. On each requested attempt it first checks the coprocessor encoding. If the encoding is the command's, it then walks a fixed-priority chain of permission checks. The inputs to that chain are the current privilege level, the register width of levels 1 and 2, whether the hypervisor is enabled, whether level 0 runs under a host kernel, and the user-enable, coprocessor-trap, general-trap, fine-grained-trap and nested-virtualization control bits.

The result is registered and appears one clock after the request. It is one of four one-hot outcomes: execute, trap to level 1, trap to level 2, or undefined. A 6-bit syndrome class travels with it for the trap outcomes. The block does no exception entry and does not perform the restriction itself. The surrounding pipeline consumes the outcome.

Top module: `rctx_trap_router`

## Requirements
- R1: Outputs are produced only for a request whose encoding is coprocessor 15, opc1 0, CRn 7, CRm 3, opc2 7. One cycle after a non-matching request, or after a cycle with no request, all four outcome outputs and the syndrome are zero.
- R2: When the restriction feature flag is clear, a matching request at any level yields undefined.
- R3: One cycle after a matching request, exactly one outcome output is high. The syndrome is zero unless a trap outcome is high.
- R4: At level 0 (cur_el_i = 0), with level 1 in 64-bit mode, host mode inactive and the level-1 64-bit user-enable clear, the command traps with syndrome 0x03. It goes to level 2 if the hypervisor is enabled in 64-bit mode with its 64-bit general-trap bit set, and to level 1 otherwise.
- R5: At level 0, with level 1 in 32-bit mode and its 32-bit user-enable clear, the command traps to level 2. The syndrome is 0x03 when the hypervisor is enabled in 64-bit mode with the 64-bit general-trap bit set. It is 0x00 when the hypervisor is enabled in 32-bit mode with the 32-bit general-trap bit set. In every other case the command is undefined.
- R6: Once the user-enable checks pass, an enabled hypervisor's coprocessor-trap bit for this register group traps to level 2 with syndrome 0x03 from level 0 or level 1. The 64-bit trap bit applies with a 64-bit hypervisor and, at level 0, only outside host mode. The 32-bit trap bit applies with a 32-bit hypervisor.
- R7: At level 0, a set fine-grained trap bit traps to level 2 with syndrome 0x03. This holds only when the hypervisor is enabled, level 1 is 64-bit, host mode is inactive, the fine-grained feature is present, and level 3 is either absent or has fine-grained traps enabled. It takes effect only after the R4 to R6 checks pass.
- R8: At level 0 in host mode, with the hypervisor enabled in 64-bit mode, a clear level-2 user-enable traps to level 2 with syndrome 0x03, after all earlier checks.
- R9: At level 1 with a 64-bit enabled hypervisor, a set nested-virtualization bit traps to level 2 with syndrome 0x03. This check is evaluated after the coprocessor-trap check.
- R10: With the feature present, a matching request at level 2 or level 3 always executes.
- R11: While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An instruction attempt is presented this cycle |
| coproc_i | input | 4 | Coprocessor number |
| opc1_i | input | 3 | First opcode field |
| crn_i | input | 4 | Primary register number |
| crm_i | input | 4 | Secondary register number |
| opc2_i | input | 3 | Second opcode field |
| cur_el_i | input | 2 | Current privilege level, 0 to 3 |
| el1_is32_i | input | 1 | Level 1 uses 32-bit registers |
| el2_is32_i | input | 1 | Level 2 uses 32-bit registers |
| el2_en_i | input | 1 | Hypervisor enabled for the current security state |
| host_mode_i | input | 1 | Level 0 runs under a host kernel at level 2 |
| feat_restrict_i | input | 1 | Restriction feature present |
| feat_fgt_i | input | 1 | Fine-grained trap feature present |
| el3_present_i | input | 1 | Level 3 implemented |
| el3_fgt_en_i | input | 1 | Level 3 permits fine-grained traps |
| uen_el1_64_i | input | 1 | Level-1 64-bit user enable for the command |
| uen_el1_32_i | input | 1 | Level-1 32-bit user enable for the command |
| uen_el2_i | input | 1 | Level-2 user enable used in host mode |
| tge_64_i | input | 1 | 64-bit hypervisor general-trap bit |
| tge_32_i | input | 1 | 32-bit hypervisor general-trap bit |
| cp_trap_64_i | input | 1 | 64-bit hypervisor coprocessor-trap bit for CRn 7 |
| cp_trap_32_i | input | 1 | 32-bit hypervisor coprocessor-trap bit for CRn 7 |
| fgt_trap_i | input | 1 | Fine-grained trap bit for this command |
| nv_i | input | 1 | Nested-virtualization enable |
| exec_o | output | 1 | Command executes |
| trap_el1_o | output | 1 | Trap to level 1 |
| trap_el2_o | output | 1 | Trap to level 2 |
| undef_o | output | 1 | Command is undefined |
| ec_o | output | 6 | Syndrome class of the trap |

## Verification
The bench targets priority collisions where several trap conditions are true together. Three collisions matter most: a clear user-enable against a set coprocessor-trap bit, a coprocessor-trap bit against the nested-virtualization bit at level 1, and the fine-grained trap against host mode. A chain in the wrong order would route these to the wrong level or report the wrong syndrome. The bench also covers the 32-bit hypervisor route, where the syndrome must read 0x00, and the case where no general-trap bit is set, which must give undefined and not a trap. A design that ignored the feature flag would execute at levels 2 and 3 where it must report undefined. A design that mis-gated the fine-grained feature or the level-3 permission would trap when it should execute.

// File: rtl/rctx_pkg.sv
package rctx_pkg;
  localparam int EC_W = 6;
  localparam logic [EC_W-1:0] EC_SYS  = 6'h03;
  localparam logic [EC_W-1:0] EC_HGEN = 6'h00;

  typedef enum logic [1:0] {
    OUT_EXEC  = 2'd0,
    OUT_TEL1  = 2'd1,
    OUT_TEL2  = 2'd2,
    OUT_UNDEF = 2'd3
  } outcome_e;

  typedef struct packed {
    outcome_e        kind;
    logic [EC_W-1:0] ec;
  } verdict_t;

  function automatic verdict_t mk(outcome_e k, logic [EC_W-1:0] e);
    verdict_t v;
    v.kind = k;
    v.ec   = e;
    return v;
  endfunction
endpackage

// File: rtl/rctx_decode.sv
module rctx_decode #(
  parameter int          CP_W   = 4,
  parameter int          OP1_W  = 3,
  parameter int          CR_W   = 4,
  parameter int          OP2_W  = 3,
  parameter logic [3:0]  CP_VAL  = 4'd15,
  parameter logic [2:0]  OP1_VAL = 3'd0,
  parameter logic [3:0]  CRN_VAL = 4'd7,
  parameter logic [3:0]  CRM_VAL = 4'd3,
  parameter logic [2:0]  OP2_VAL = 3'd7
) (
  input  logic [CP_W-1:0]  coproc_i,
  input  logic [OP1_W-1:0] opc1_i,
  input  logic [CR_W-1:0]  crn_i,
  input  logic [CR_W-1:0]  crm_i,
  input  logic [OP2_W-1:0] opc2_i,
  output logic             hit_o
);
  localparam int N_FIELDS = 5;
  logic [N_FIELDS-1:0] fld_ok;

  always_comb begin
    fld_ok[0] = (coproc_i == CP_W'(CP_VAL));
    fld_ok[1] = (opc1_i   == OP1_W'(OP1_VAL));
    fld_ok[2] = (crn_i    == CR_W'(CRN_VAL));
    fld_ok[3] = (crm_i    == CR_W'(CRM_VAL));
    fld_ok[4] = (opc2_i   == OP2_W'(OP2_VAL));
  end

  assign hit_o = &fld_ok;
endmodule

// File: rtl/rctx_el0_chain.sv
module rctx_el0_chain
  import rctx_pkg::*;
(
  input  logic     el1_is32_i,
  input  logic     el2_is32_i,
  input  logic     el2_en_i,
  input  logic     host_i,
  input  logic     feat_fgt_i,
  input  logic     el3_present_i,
  input  logic     el3_fgt_en_i,
  input  logic     uen_el1_64_i,
  input  logic     uen_el1_32_i,
  input  logic     uen_el2_i,
  input  logic     tge_64_i,
  input  logic     tge_32_i,
  input  logic     cp_trap_64_i,
  input  logic     cp_trap_32_i,
  input  logic     fgt_trap_i,
  output verdict_t verdict_o
);
  logic hyp64, hyp32, fgt_live;

  assign hyp64    = el2_en_i & ~el2_is32_i;
  assign hyp32    = el2_en_i &  el2_is32_i;
  assign fgt_live = feat_fgt_i & (~el3_present_i | el3_fgt_en_i);

  // first matching rung wins
  always_comb begin
    if (~el1_is32_i & ~host_i & ~uen_el1_64_i) begin
      verdict_o = (hyp64 & tge_64_i) ? mk(OUT_TEL2, EC_SYS) : mk(OUT_TEL1, EC_SYS);
    end else if (el1_is32_i & ~uen_el1_32_i) begin
      if (hyp64 & tge_64_i)      verdict_o = mk(OUT_TEL2, EC_SYS);
      else if (hyp32 & tge_32_i) verdict_o = mk(OUT_TEL2, EC_HGEN);
      else                       verdict_o = mk(OUT_UNDEF, '0);
    end else if (hyp64 & ~host_i & cp_trap_64_i) begin
      verdict_o = mk(OUT_TEL2, EC_SYS);
    end else if (hyp32 & cp_trap_32_i) begin
      verdict_o = mk(OUT_TEL2, EC_SYS);
    end else if (el2_en_i & ~el1_is32_i & ~host_i & fgt_live & fgt_trap_i) begin
      verdict_o = mk(OUT_TEL2, EC_SYS);
    end else if (host_i & ~uen_el2_i) begin
      verdict_o = mk(OUT_TEL2, EC_SYS);
    end else begin
      verdict_o = mk(OUT_EXEC, '0);
    end
  end
endmodule

// File: rtl/rctx_el1_chain.sv
module rctx_el1_chain
  import rctx_pkg::*;
(
  input  logic     el2_is32_i,
  input  logic     el2_en_i,
  input  logic     cp_trap_64_i,
  input  logic     cp_trap_32_i,
  input  logic     nv_i,
  output verdict_t verdict_o
);
  logic hyp64, hyp32;

  assign hyp64 = el2_en_i & ~el2_is32_i;
  assign hyp32 = el2_en_i &  el2_is32_i;

  always_comb begin
    if (hyp64 & cp_trap_64_i)      verdict_o = mk(OUT_TEL2, EC_SYS);
    else if (hyp32 & cp_trap_32_i) verdict_o = mk(OUT_TEL2, EC_SYS);
    else if (hyp64 & nv_i)         verdict_o = mk(OUT_TEL2, EC_SYS);
    else                           verdict_o = mk(OUT_EXEC, '0);
  end
endmodule

// File: rtl/rctx_trap_router.sv
module rctx_trap_router
  import rctx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [3:0]      coproc_i,
  input  logic [2:0]      opc1_i,
  input  logic [3:0]      crn_i,
  input  logic [3:0]      crm_i,
  input  logic [2:0]      opc2_i,
  input  logic [1:0]      cur_el_i,
  input  logic            el1_is32_i,
  input  logic            el2_is32_i,
  input  logic            el2_en_i,
  input  logic            host_mode_i,
  input  logic            feat_restrict_i,
  input  logic            feat_fgt_i,
  input  logic            el3_present_i,
  input  logic            el3_fgt_en_i,
  input  logic            uen_el1_64_i,
  input  logic            uen_el1_32_i,
  input  logic            uen_el2_i,
  input  logic            tge_64_i,
  input  logic            tge_32_i,
  input  logic            cp_trap_64_i,
  input  logic            cp_trap_32_i,
  input  logic            fgt_trap_i,
  input  logic            nv_i,
  output logic            exec_o,
  output logic            trap_el1_o,
  output logic            trap_el2_o,
  output logic            undef_o,
  output logic [EC_W-1:0] ec_o
);
  localparam int N_OUT = 4;

  logic     hit, host_eff;
  verdict_t v_el0, v_el1, v_sel;
  logic [N_OUT-1:0] onehot_d, onehot_q;
  logic [EC_W-1:0]  ec_d, ec_q;

  rctx_decode u_dec (
    .coproc_i (coproc_i),
    .opc1_i   (opc1_i),
    .crn_i    (crn_i),
    .crm_i    (crm_i),
    .opc2_i   (opc2_i),
    .hit_o    (hit)
  );

  // host mode only exists under a 64-bit hypervisor
  assign host_eff = host_mode_i & el2_en_i & ~el2_is32_i;

  rctx_el0_chain u_el0 (
    .el1_is32_i    (el1_is32_i),
    .el2_is32_i    (el2_is32_i),
    .el2_en_i      (el2_en_i),
    .host_i        (host_eff),
    .feat_fgt_i    (feat_fgt_i),
    .el3_present_i (el3_present_i),
    .el3_fgt_en_i  (el3_fgt_en_i),
    .uen_el1_64_i  (uen_el1_64_i),
    .uen_el1_32_i  (uen_el1_32_i),
    .uen_el2_i     (uen_el2_i),
    .tge_64_i      (tge_64_i),
    .tge_32_i      (tge_32_i),
    .cp_trap_64_i  (cp_trap_64_i),
    .cp_trap_32_i  (cp_trap_32_i),
    .fgt_trap_i    (fgt_trap_i),
    .verdict_o     (v_el0)
  );

  rctx_el1_chain u_el1 (
    .el2_is32_i   (el2_is32_i),
    .el2_en_i     (el2_en_i),
    .cp_trap_64_i (cp_trap_64_i),
    .cp_trap_32_i (cp_trap_32_i),
    .nv_i         (nv_i),
    .verdict_o    (v_el1)
  );

  always_comb begin
    if (!feat_restrict_i) begin
      v_sel = mk(OUT_UNDEF, '0);
    end else begin
      unique case (cur_el_i)
        2'd0:    v_sel = v_el0;
        2'd1:    v_sel = v_el1;
        default: v_sel = mk(OUT_EXEC, '0);
      endcase
    end
  end

  always_comb begin
    onehot_d = '0;
    ec_d     = '0;
    if (req_valid_i && hit) begin
      onehot_d[v_sel.kind] = 1'b1;
      if (v_sel.kind == OUT_TEL1 || v_sel.kind == OUT_TEL2) ec_d = v_sel.ec;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      onehot_q <= '0;
      ec_q     <= '0;
    end else begin
      onehot_q <= onehot_d;
      ec_q     <= ec_d;
    end
  end

  assign exec_o     = onehot_q[OUT_EXEC];
  assign trap_el1_o = onehot_q[OUT_TEL1];
  assign trap_el2_o = onehot_q[OUT_TEL2];
  assign undef_o    = onehot_q[OUT_UNDEF];
  assign ec_o       = ec_q;
endmodule

// File: rtl/rctx_trap_router_chk.sv
module rctx_trap_router_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [3:0] coproc_i,
  input logic [2:0] opc1_i,
  input logic [3:0] crn_i,
  input logic [3:0] crm_i,
  input logic [2:0] opc2_i,
  input logic [1:0] cur_el_i,
  input logic       feat_restrict_i,
  input logic       exec_o,
  input logic       trap_el1_o,
  input logic       trap_el2_o,
  input logic       undef_o,
  input logic [5:0] ec_o
);
  logic armed;
  logic enc_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assign enc_ok = req_valid_i && coproc_i == 4'd15 && opc1_i == 3'd0 &&
                  crn_i == 4'd7 && crm_i == 4'd3 && opc2_i == 3'd7;

  assert_at_most_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({exec_o, trap_el1_o, trap_el2_o, undef_o}) <= 1);

  assert_one_on_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(enc_ok) |-> $countones({exec_o, trap_el1_o, trap_el2_o, undef_o}) == 1);

  assert_ec_only_trap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ec_o != 6'd0) |-> (trap_el1_o || trap_el2_o));

  assert_quiet_on_miss_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(enc_ok) |-> !(exec_o || trap_el1_o || trap_el2_o || undef_o) && ec_o == 6'd0);

  assert_no_feature_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(enc_ok && !feat_restrict_i) |-> undef_o);

  assert_high_levels_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(enc_ok && feat_restrict_i && cur_el_i[1]) |-> exec_o);
endmodule

bind rctx_trap_router rctx_trap_router_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .coproc_i        (coproc_i),
  .opc1_i          (opc1_i),
  .crn_i           (crn_i),
  .crm_i           (crm_i),
  .opc2_i          (opc2_i),
  .cur_el_i        (cur_el_i),
  .feat_restrict_i (feat_restrict_i),
  .exec_o          (exec_o),
  .trap_el1_o      (trap_el1_o),
  .trap_el2_o      (trap_el2_o),
  .undef_o         (undef_o),
  .ec_o            (ec_o)
);

// File: tb/sim_rctx_trap_router.sv
module sim_rctx_trap_router;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid;
  logic [3:0] coproc, crn, crm;
  logic [2:0] opc1, opc2;
  logic [1:0] cur_el;
  logic el1_is32, el2_is32, el2_en, host_mode, feat_restrict, feat_fgt;
  logic el3_present, el3_fgt_en, uen_el1_64, uen_el1_32, uen_el2;
  logic tge_64, tge_32, cp_trap_64, cp_trap_32, fgt_trap, nv;
  logic exec_w, tel1_w, tel2_w, undef_w;
  logic [5:0] ec_w;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rctx_trap_router u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid),
    .coproc_i(coproc), .opc1_i(opc1), .crn_i(crn), .crm_i(crm), .opc2_i(opc2),
    .cur_el_i(cur_el), .el1_is32_i(el1_is32), .el2_is32_i(el2_is32),
    .el2_en_i(el2_en), .host_mode_i(host_mode), .feat_restrict_i(feat_restrict),
    .feat_fgt_i(feat_fgt), .el3_present_i(el3_present), .el3_fgt_en_i(el3_fgt_en),
    .uen_el1_64_i(uen_el1_64), .uen_el1_32_i(uen_el1_32), .uen_el2_i(uen_el2),
    .tge_64_i(tge_64), .tge_32_i(tge_32), .cp_trap_64_i(cp_trap_64),
    .cp_trap_32_i(cp_trap_32), .fgt_trap_i(fgt_trap), .nv_i(nv),
    .exec_o(exec_w), .trap_el1_o(tel1_w), .trap_el2_o(tel2_w), .undef_o(undef_w),
    .ec_o(ec_w)
  );

  // {exec, tel1, tel2, undef, ec[5:0]}
  localparam logic [9:0] X_EXEC  = 10'b1000_000000;
  localparam logic [9:0] X_UNDEF = 10'b0001_000000;
  localparam logic [9:0] X_T1    = 10'b0100_000011;
  localparam logic [9:0] X_T2    = 10'b0010_000011;
  localparam logic [9:0] X_T2H   = 10'b0010_000000;

  function automatic logic [9:0] model();
    logic h64, h32, host, fgt_ok;
    h64    = el2_en & ~el2_is32;
    h32    = el2_en & el2_is32;
    host   = host_mode & h64;
    fgt_ok = feat_fgt & (~el3_present | el3_fgt_en);
    if (!(req_valid && coproc == 4'd15 && opc1 == 3'd0 && crn == 4'd7 &&
          crm == 4'd3 && opc2 == 3'd7)) return 10'd0;
    if (!feat_restrict) return X_UNDEF;
    if (cur_el >= 2'd2) return X_EXEC;
    if (cur_el == 2'd1) begin
      if ((h64 && cp_trap_64) || (h32 && cp_trap_32) || (h64 && nv)) return X_T2;
      return X_EXEC;
    end
    if (!el1_is32 && !host && !uen_el1_64) return (h64 && tge_64) ? X_T2 : X_T1;
    if (el1_is32 && !uen_el1_32) begin
      if (h64 && tge_64) return X_T2;
      if (h32 && tge_32) return X_T2H;
      return X_UNDEF;
    end
    if (h64 && !host && cp_trap_64) return X_T2;
    if (h32 && cp_trap_32) return X_T2;
    if (el2_en && !el1_is32 && !host && fgt_ok && fgt_trap) return X_T2;
    if (host && !uen_el2) return X_T2;
    return X_EXEC;
  endfunction

  function automatic logic [9:0] seen();
    return {exec_w, tel1_w, tel2_w, undef_w, ec_w};
  endfunction

  task automatic compare(input string tag, input logic [9:0] exp);
    n_run++;
    if (seen() !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, seen(), exp);
    end
  endtask

  // inputs set at a negedge; result registered at next posedge
  task automatic step(input string tag);
    logic [9:0] exp;
    exp = model();
    @(posedge clk);
    @(negedge clk);
    compare(tag, exp);
  endtask

  task automatic base(input logic [1:0] el);
    req_valid = 1'b1; coproc = 4'd15; opc1 = 3'd0; crn = 4'd7; crm = 4'd3; opc2 = 3'd7;
    cur_el = el; el1_is32 = 1'b0; el2_is32 = 1'b0; el2_en = 1'b1; host_mode = 1'b0;
    feat_restrict = 1'b1; feat_fgt = 1'b1; el3_present = 1'b1; el3_fgt_en = 1'b1;
    uen_el1_64 = 1'b1; uen_el1_32 = 1'b1; uen_el2 = 1'b1; tge_64 = 1'b0; tge_32 = 1'b0;
    cp_trap_64 = 1'b0; cp_trap_32 = 1'b0; fgt_trap = 1'b0; nv = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0007));
    base(2'd0);
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R11", 10'd0);
    rst_ni = 1'b1;

    base(2'd0); step("R10 el0 all enables set");
    base(2'd0); crm = 4'd4; step("R1 wrong crm");
    base(2'd0); coproc = 4'd14; step("R1 wrong coproc");
    base(2'd2); req_valid = 1'b0; step("R1 no request");
    base(2'd3); feat_restrict = 1'b0; step("R2");
    base(2'd2); cp_trap_64 = 1'b1; nv = 1'b1; step("R10 el2");
    base(2'd3); step("R10 el3");
    base(2'd0); uen_el1_64 = 1'b0; step("R4 to el1");
    base(2'd0); uen_el1_64 = 1'b0; tge_64 = 1'b1; step("R4 to el2");
    base(2'd0); uen_el1_64 = 1'b0; cp_trap_64 = 1'b1; step("R4 beats R6");
    base(2'd0); el1_is32 = 1'b1; uen_el1_32 = 1'b0; step("R5 undef");
    base(2'd0); el1_is32 = 1'b1; uen_el1_32 = 1'b0; tge_64 = 1'b1; step("R5 64-bit hyp");
    base(2'd0); el1_is32 = 1'b1; el2_is32 = 1'b1; uen_el1_32 = 1'b0; tge_32 = 1'b1;
    step("R5 32-bit hyp ec 0");
    base(2'd0); cp_trap_64 = 1'b1; step("R6 el0");
    base(2'd1); el1_is32 = 1'b1; el2_is32 = 1'b1; cp_trap_32 = 1'b1; step("R6 el1 32");
    base(2'd1); el2_en = 1'b0; cp_trap_64 = 1'b1; step("R6 hyp off");
    base(2'd0); fgt_trap = 1'b1; step("R7 trap");
    base(2'd0); fgt_trap = 1'b1; el3_fgt_en = 1'b0; step("R7 el3 blocks");
    base(2'd0); fgt_trap = 1'b1; el3_present = 1'b0; el3_fgt_en = 1'b0; step("R7 no el3");
    base(2'd0); fgt_trap = 1'b1; feat_fgt = 1'b0; step("R7 no feature");
    base(2'd0); host_mode = 1'b1; uen_el2 = 1'b0; uen_el1_64 = 1'b0; fgt_trap = 1'b1;
    cp_trap_64 = 1'b1; step("R8 host");
    base(2'd0); host_mode = 1'b1; step("R8 host enabled");
    base(2'd1); nv = 1'b1; step("R9 nv");
    base(2'd1); nv = 1'b1; el2_en = 1'b0; step("R9 hyp off");

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      base(2'(r[1:0]));
      req_valid = (r[31:29] != 3'd0);
      if (r[28:26] == 3'd0) crn = 4'($urandom_range(0, 15));
      el1_is32 = r[2]; el2_is32 = r[3] & r[2]; el2_en = r[4]; host_mode = r[5];
      feat_restrict = (r[25:23] != 3'd0); feat_fgt = r[6];
      el3_present = r[7]; el3_fgt_en = r[8]; uen_el1_64 = r[9]; uen_el1_32 = r[10];
      uen_el2 = r[11]; tge_64 = r[12]; tge_32 = r[13]; cp_trap_64 = r[14] & r[15];
      cp_trap_32 = r[16] & r[17]; fgt_trap = r[18]; nv = r[19] & r[20];
      step("R3 random");
    end

    base(2'd0); req_valid = 1'b0; step("R1 idle");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule